// File: doc/BRIEF.md
# Hashed Flow Filter Table Engine

This block holds packet-steering filters in on-chip storage arranged as hash buckets, each bucket holding a fixed number of slots. A host loads a hash word first: a bucket index, a key and a valid flag. The key is a signature in signature mode and a software index in perfect mode. The host then issues a command word with an opcode (add, query or remove) and, for an add, a destination queue, a queue-enable flag and a drop flag. The engine holds the opcode in its readback register while the command is running. It clears the opcode to zero when the command finishes, so software polls the readback until it reads zero.

A control write latches the allocation code, the match mode and the drop queue, then sweeps the table clear one bucket per cycle. The init-done flag rises when the sweep ends, and commands are refused until then. The allocation code sets how many buckets are in use and masks the bucket index to match. The code also sets the table capacity, which the nearly-full interrupt measures free slots against. Query results (hit flag, stored queue, stored enable) and an error flag are updated in the cycle the opcode clears.

Top module: `flow_bucket_table`

## Requirements
- R1: Out of reset, init_done, the opcode readback, qry_hit, cmd_err and irq_nearly_full are all 0.
- R2: A cfg_wr starts a clearing sweep. init_done is 0 for exactly NB = 2^BKT_W cycles after the write edge and then reads 1. A cmd_wr while init_done is 0 is ignored, and the readback stays 0.
- R3: An accepted command shows its opcode (1 add, 2 query, 3 remove, 0 idle) on cmd_op_rb for exactly CMD_LAT cycles, then reads 0. Results appear in the same cycle the opcode clears.
- R4: While cmd_op_rb is nonzero, cmd_wr and hash_wr are ignored. No second command runs, and the latched hash word is unchanged.
- R5: A query after an add to the same bucket and key sets qry_hit=1 and returns the stored queue and enable. A query for a key not stored sets qry_hit=0 with a queue of 0.
- R6: An add whose bucket and key are already stored overwrites that slot's queue and enable. It does not use a new slot.
- R7: A remove of a stored entry frees it, and a later query misses. A remove of an absent entry sets cmd_err=1.
- R8: Each bucket holds at most DEPTH (10) entries. An add of a new key to a full bucket sets cmd_err=1 and stores nothing.
- R9: Allocation code 0 uses the low BKT_W-2 bucket bits, code 1 the low BKT_W-1 bits, code 2 all bits, and code 3 acts as code 0. Under code 0, bucket indices 1 and 5 reach the same bucket; under code 2 they do not.
- R10: An add whose hash word has hash_vld=0 sets cmd_err=1 and stores nothing.
- R11: In perfect mode (cfg_perfect=1), an add with cmd_drop=1 stores the configured drop queue instead of cmd_queue. In signature mode the same add sets cmd_err=1 and stores nothing.
- R12: irq_nearly_full is 1 exactly when init_done is 1 and the free slots (capacity minus stored entries) are at most FREE_THR. Capacity is DEPTH times the number of buckets in use.
- R13: A new cfg_wr removes every stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control write: latch configuration and start the clearing sweep |
| cfg_alloc | input | 2 | Allocation code (0 quarter, 1 half, 2 full table) |
| cfg_perfect | input | 1 | 1 = perfect match mode, 0 = signature mode |
| cfg_drop_q | input | QW | Drop queue number used in perfect mode |
| hash_wr | input | 1 | Hash word write strobe |
| hash_bkt | input | BKT_W | Bucket index |
| hash_key | input | KEY_W | Signature or software index |
| hash_vld | input | 1 | Hash word valid flag |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 2 | Opcode: 1 add, 2 query, 3 remove |
| cmd_queue | input | QW | Destination queue for add |
| cmd_qena | input | 1 | Queue-enable flag stored with the entry |
| cmd_drop | input | 1 | Steer to the drop queue |
| init_done | output | 1 | Clearing sweep finished |
| cmd_op_rb | output | 2 | Opcode readback, 0 when idle |
| qry_hit | output | 1 | Last query found an entry |
| qry_queue | output | QW | Queue of the entry the last query found |
| qry_qena | output | 1 | Queue enable of the entry the last query found |
| cmd_err | output | 1 | Last command was refused or found nothing to remove |
| irq_nearly_full | output | 1 | Free slots at or below the threshold |

## Verification
The hardest state to reach from the ports is the nearly-full threshold. It depends on a global count of stored entries rather than on any single bucket, so it takes close to a hundred accepted adds. Those adds also have to be spread so that no bucket overflows its ten slots first. The stimulus selects the full allocation code and walks the bucket index round-robin with a rising key. The interrupt is sampled one entry below the threshold and again exactly at it. A second corner is a command and a hash word arriving together while the engine is busy. The bench issues both inside an add's latency window, then queries without rewriting the hash, which shows that neither took effect.

// File: rtl/fbt_pkg.sv
// Shared types for the hashed flow filter table.
// Assumes: opcode encoding is fixed and shared with software.
package fbt_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_ADD    = 2'd1,
        OP_QUERY  = 2'd2,
        OP_REMOVE = 2'd3
    } fbt_op_e;
endpackage

// File: rtl/fbt_slot_scan.sv
// Scans the slots of one bucket: finds the lowest slot whose key matches
// and the lowest free slot. Purely combinational.
// Assumes: DEPTH >= 2.
module fbt_slot_scan #(
    parameter int DEPTH = 10,
    parameter int KEY_W = 8,
    localparam int SW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            slot_vld,
    input  logic [DEPTH-1:0][KEY_W-1:0] slot_key,
    input  logic [KEY_W-1:0]            key_in,
    output logic                        hit,
    output logic [SW-1:0]               hit_idx,
    output logic                        has_free,
    output logic [SW-1:0]               free_idx
);
    logic [DEPTH-1:0] match;

    // Per-slot key comparators.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = slot_vld[g] && (slot_key[g] == key_in);
    end

    // Lowest-index priority pick for the match and the free slot.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = SW'(i);
            end
            if (!slot_vld[i]) begin
                has_free = 1'b1;
                free_idx = SW'(i);
            end
        end
    end
endmodule

// File: rtl/fbt_ctrl.sv
// Sequencer: runs the clearing sweep after a control write, accepts
// commands only when idle and initialised, and holds each command for a
// fixed latency before pulsing exec.
// Assumes: NB is a power of two, LAT >= 1.
module fbt_ctrl
    import fbt_pkg::*;
#(
    parameter int NB  = 16,
    parameter int LAT = 4,
    localparam int IW = $clog2(NB),
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cmd_wr,
    input  logic [1:0]    cmd_op,
    output logic          init_run,
    output logic [IW-1:0] init_idx,
    output logic          init_done,
    output logic [1:0]    op_q,
    output logic          idle,
    output logic          cfg_take,
    output logic          accept,
    output logic          exec
);
    logic [CW-1:0] cnt;

    assign idle     = (op_q == OP_NONE);
    assign cfg_take = cfg_wr && idle;
    assign accept   = cmd_wr && (cmd_op != OP_NONE) && idle && init_done
                      && !init_run && !cfg_wr;
    assign exec     = !idle && (cnt == '0);

    // Sweep state and command latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_run  <= 1'b0;
            init_idx  <= '0;
            init_done <= 1'b0;
            op_q      <= OP_NONE;
            cnt       <= '0;
        end else begin
            if (cfg_take) begin
                init_run  <= 1'b1;
                init_idx  <= '0;
                init_done <= 1'b0;
            end else if (init_run) begin
                init_idx <= init_idx + 1'b1;
                if (init_idx == IW'(NB - 1)) begin
                    init_run  <= 1'b0;
                    init_done <= 1'b1;
                end
            end
            if (accept) begin
                op_q <= cmd_op;
                cnt  <= CW'(LAT - 1);
            end else if (!idle) begin
                if (cnt != '0) cnt <= cnt - 1'b1;
                else           op_q <= OP_NONE;
            end
        end
    end
endmodule

// File: rtl/flow_bucket_table.sv
// Hashed flow filter table: bucketed slot storage with add, query and
// remove commands, allocation-code bucket masking and a nearly-full flag.
// Assumes: hash computation happens outside; BKT_W >= 2.
module flow_bucket_table
    import fbt_pkg::*;
#(
    parameter int BKT_W    = 4,
    parameter int DEPTH    = 10,
    parameter int KEY_W    = 8,
    parameter int QW       = 4,
    parameter int CMD_LAT  = 4,
    parameter int FREE_THR = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_alloc,
    input  logic             cfg_perfect,
    input  logic [QW-1:0]    cfg_drop_q,
    input  logic             hash_wr,
    input  logic [BKT_W-1:0] hash_bkt,
    input  logic [KEY_W-1:0] hash_key,
    input  logic             hash_vld,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_op,
    input  logic [QW-1:0]    cmd_queue,
    input  logic             cmd_qena,
    input  logic             cmd_drop,
    output logic             init_done,
    output logic [1:0]       cmd_op_rb,
    output logic             qry_hit,
    output logic [QW-1:0]    qry_queue,
    output logic             qry_qena,
    output logic             cmd_err,
    output logic             irq_nearly_full
);
    localparam int NB = 1 << BKT_W;
    localparam int SW = $clog2(DEPTH);
    localparam int UW = $clog2(NB * DEPTH + 1);

    logic             init_run, idle, cfg_take, accept, exec;
    logic [BKT_W-1:0] init_idx;
    logic [1:0]       op_q;

    logic [BKT_W-1:0] mask_q;
    logic [UW-1:0]    cap_q, used_q;
    logic             perf_q;
    logic [QW-1:0]    dropq_q;
    logic [BKT_W-1:0] h_bkt;
    logic [KEY_W-1:0] h_key;
    logic             h_vld;
    logic [QW-1:0]    c_queue;
    logic             c_qena, c_drop;

    logic [NB-1:0][DEPTH-1:0] vld_m;
    logic [KEY_W-1:0] key_m [NB][DEPTH];
    logic [QW-1:0]    q_m   [NB][DEPTH];
    logic             qe_m  [NB][DEPTH];

    logic [BKT_W-1:0]            bkt_eff;
    logic [DEPTH-1:0][KEY_W-1:0] bkt_keys;
    logic                        hit, has_free;
    logic [SW-1:0]               hit_idx, free_idx;
    logic                        is_add, is_qry, is_rem, drop_bad;
    logic                        add_new, add_upd, rem_ok, err_now;
    logic [QW-1:0]               st_queue;

    fbt_ctrl #(.NB(NB), .LAT(CMD_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cmd_wr(cmd_wr),
        .cmd_op(cmd_op), .init_run(init_run), .init_idx(init_idx),
        .init_done(init_done), .op_q(op_q), .idle(idle),
        .cfg_take(cfg_take), .accept(accept), .exec(exec)
    );

    assign bkt_eff = h_bkt & mask_q;

    // Gather the addressed bucket's keys for the scanner.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) bkt_keys[i] = key_m[bkt_eff][i];
    end

    fbt_slot_scan #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_scan (
        .slot_vld(vld_m[bkt_eff]), .slot_key(bkt_keys), .key_in(h_key),
        .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
    );

    // Decode the outcome of the command being executed.
    always_comb begin
        is_add   = (op_q == OP_ADD);
        is_qry   = (op_q == OP_QUERY);
        is_rem   = (op_q == OP_REMOVE);
        drop_bad = c_drop && !perf_q;
        add_upd  = is_add && h_vld && !drop_bad && hit;
        add_new  = is_add && h_vld && !drop_bad && !hit && has_free;
        rem_ok   = is_rem && hit;
        err_now  = (is_add && !(add_upd || add_new)) || (is_rem && !hit);
        st_queue = c_drop ? dropq_q : c_queue;
    end

    // Configuration latch: bucket mask and capacity from the allocation code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            cap_q   <= '0;
            perf_q  <= 1'b0;
            dropq_q <= '0;
        end else if (cfg_take) begin
            perf_q  <= cfg_perfect;
            dropq_q <= cfg_drop_q;
            case (cfg_alloc)
                2'd1:    begin mask_q <= BKT_W'(NB / 2 - 1); cap_q <= UW'(NB / 2 * DEPTH); end
                2'd2:    begin mask_q <= BKT_W'(NB - 1);     cap_q <= UW'(NB * DEPTH);     end
                default: begin mask_q <= BKT_W'(NB / 4 - 1); cap_q <= UW'(NB / 4 * DEPTH); end
            endcase
        end
    end

    // Hash word and command argument latches, taken only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_bkt <= '0; h_key <= '0; h_vld <= 1'b0;
            c_queue <= '0; c_qena <= 1'b0; c_drop <= 1'b0;
        end else begin
            if (hash_wr && idle) begin
                h_bkt <= hash_bkt; h_key <= hash_key; h_vld <= hash_vld;
            end
            if (accept) begin
                c_queue <= cmd_queue; c_qena <= cmd_qena; c_drop <= cmd_drop;
            end
        end
    end

    // Slot valid bits: reset, sweep clear, add and remove.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_m <= '0;
        end else if (init_run) begin
            vld_m[init_idx] <= '0;
        end else if (exec) begin
            if (add_new) vld_m[bkt_eff][free_idx] <= 1'b1;
            if (rem_ok)  vld_m[bkt_eff][hit_idx]  <= 1'b0;
        end
    end

    // Slot payload: key on a new entry, queue and enable on any good add.
    always_ff @(posedge clk) begin
        if (exec && add_new) begin
            key_m[bkt_eff][free_idx] <= h_key;
            q_m[bkt_eff][free_idx]   <= st_queue;
            qe_m[bkt_eff][free_idx]  <= c_qena;
        end else if (exec && add_upd) begin
            q_m[bkt_eff][hit_idx]  <= st_queue;
            qe_m[bkt_eff][hit_idx] <= c_qena;
        end
    end

    // Count of stored entries for the nearly-full threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_take)      used_q <= '0;
        else if (exec && add_new)    used_q <= used_q + 1'b1;
        else if (exec && rem_ok)     used_q <= used_q - 1'b1;
    end

    // Result registers updated when a command completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qry_hit   <= 1'b0;
            qry_queue <= '0;
            qry_qena  <= 1'b0;
            cmd_err   <= 1'b0;
        end else if (exec) begin
            cmd_err <= err_now;
            if (is_qry) begin
                qry_hit   <= hit;
                qry_queue <= hit ? q_m[bkt_eff][hit_idx] : '0;
                qry_qena  <= hit && qe_m[bkt_eff][hit_idx];
            end
        end
    end

    assign cmd_op_rb       = op_q;
    assign irq_nearly_full = init_done && ((cap_q - used_q) <= UW'(FREE_THR));
endmodule

// File: rtl/fbt_table_chk.sv
// Property checker for flow_bucket_table, attached with bind below.
// Assumes: observes ports only.
module fbt_table_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       init_done,
    input logic [1:0] cmd_op_rb,
    input logic       qry_hit,
    input logic       cmd_err,
    input logic       irq_nearly_full
);
    // No command is ever seen running before the sweep has finished.
    assert_no_cmd_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> cmd_op_rb == 2'd0);

    // A running opcode either holds or clears; it never changes to another one.
    assert_op_holds_or_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op_rb != 2'd0 |=> (cmd_op_rb == $past(cmd_op_rb) || cmd_op_rb == 2'd0));

    // The query result moves only in the cycle a command completes.
    assert_hit_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(qry_hit) |-> ($past(cmd_op_rb) != 2'd0 && cmd_op_rb == 2'd0));

    // The error flag moves only in the cycle a command completes.
    assert_err_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_err) |-> ($past(cmd_op_rb) != 2'd0 && cmd_op_rb == 2'd0));

    // The nearly-full flag needs a finished sweep.
    assert_irq_needs_init_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nearly_full |-> init_done);
endmodule

bind flow_bucket_table fbt_table_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .cmd_op_rb(cmd_op_rb),
    .qry_hit(qry_hit), .cmd_err(cmd_err), .irq_nearly_full(irq_nearly_full)
);

// File: tb/sim_flow_bucket_table.sv
// Directed bench for flow_bucket_table: one task per scenario.
module sim_flow_bucket_table;
    localparam int BKT_W = 4, DEPTH = 10, KEY_W = 8, QW = 4, LAT = 4, THR = 64;
    localparam int NB = 1 << BKT_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, cfg_perfect = 0, hash_wr = 0, hash_vld = 0;
    logic cmd_wr = 0, cmd_qena = 0, cmd_drop = 0;
    logic [1:0] cfg_alloc = 0, cmd_op = 0;
    logic [QW-1:0] cfg_drop_q = 0, cmd_queue = 0;
    logic [BKT_W-1:0] hash_bkt = 0;
    logic [KEY_W-1:0] hash_key = 0;
    logic init_done, qry_hit, qry_qena, cmd_err, irq_nearly_full;
    logic [1:0] cmd_op_rb;
    logic [QW-1:0] qry_queue;

    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    flow_bucket_table #(.BKT_W(BKT_W), .DEPTH(DEPTH), .KEY_W(KEY_W), .QW(QW),
                        .CMD_LAT(LAT), .FREE_THR(THR)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_alloc(cfg_alloc),
        .cfg_perfect(cfg_perfect), .cfg_drop_q(cfg_drop_q), .hash_wr(hash_wr),
        .hash_bkt(hash_bkt), .hash_key(hash_key), .hash_vld(hash_vld),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_queue(cmd_queue),
        .cmd_qena(cmd_qena), .cmd_drop(cmd_drop), .init_done(init_done),
        .cmd_op_rb(cmd_op_rb), .qry_hit(qry_hit), .qry_queue(qry_queue),
        .qry_qena(qry_qena), .cmd_err(cmd_err), .irq_nearly_full(irq_nearly_full)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Control write; returns the number of cycles init_done stayed low.
    task automatic do_cfg(input int code, input bit perf, input int dq, output int n);
        @(negedge clk);
        cfg_wr = 1; cfg_alloc = 2'(code); cfg_perfect = perf; cfg_drop_q = QW'(dq);
        @(negedge clk);
        cfg_wr = 0;
        n = 0;
        while (!init_done && n < 1000) begin n++; @(negedge clk); end
    endtask

    // Optional hash write, then a command; returns cycles the opcode showed.
    task automatic do_cmd(input bit wr_hash, input int op, input int bkt, input int key,
                          input bit vld, input int q, input bit qe, input bit drop,
                          output int lat);
        if (wr_hash) begin
            @(negedge clk);
            hash_wr = 1; hash_bkt = BKT_W'(bkt); hash_key = KEY_W'(key); hash_vld = vld;
        end
        @(negedge clk);
        hash_wr = 0;
        cmd_wr = 1; cmd_op = 2'(op); cmd_queue = QW'(q); cmd_qena = qe; cmd_drop = drop;
        @(negedge clk);
        cmd_wr = 0;
        lat = 0;
        while (cmd_op_rb != 0 && lat < 1000) begin lat++; @(negedge clk); end
    endtask

    task automatic add(input int bkt, input int key, input int q, input bit qe, input bit drop);
        int l;
        do_cmd(1, 1, bkt, key, 1, q, qe, drop, l);
    endtask

    task automatic query(input int bkt, input int key);
        int l;
        do_cmd(1, 2, bkt, key, 1, 0, 0, 0, l);
    endtask

    task automatic remove(input int bkt, input int key);
        int l;
        do_cmd(1, 3, bkt, key, 1, 0, 0, 0, l);
    endtask

    task automatic t_reset;
        check("R1 init_done", int'(init_done), 0);
        check("R1 op readback", int'(cmd_op_rb), 0);
        check("R1 qry_hit", int'(qry_hit), 0);
        check("R1 cmd_err", int'(cmd_err), 0);
        check("R1 irq", int'(irq_nearly_full), 0);
    endtask

    task automatic t_pre_init;
        @(negedge clk);
        cmd_wr = 1; cmd_op = 2'd1;
        @(negedge clk);
        cmd_wr = 0;
        check("R2 cmd ignored before init", int'(cmd_op_rb), 0);
    endtask

    task automatic t_init_timing;
        int n;
        do_cfg(2, 0, 0, n);
        check("R2 init cycles", n, NB);
        check("R2 init_done", int'(init_done), 1);
    endtask

    task automatic t_add_query;
        int l;
        do_cmd(1, 1, 3, 8'h21, 1, 7, 1, 0, l);
        check("R3 add latency", l, LAT);
        check("R5 add no err", int'(cmd_err), 0);
        do_cmd(1, 2, 3, 8'h21, 1, 0, 0, 0, l);
        check("R3 query latency", l, LAT);
        check("R5 query hit", int'(qry_hit), 1);
        check("R5 query queue", int'(qry_queue), 7);
        check("R5 query qena", int'(qry_qena), 1);
        query(3, 8'h22);
        check("R5 miss hit", int'(qry_hit), 0);
        check("R5 miss queue", int'(qry_queue), 0);
    endtask

    task automatic t_busy_ignore;
        int l;
        @(negedge clk);
        hash_wr = 1; hash_bkt = 2; hash_key = 8'h11; hash_vld = 1;
        @(negedge clk);
        hash_wr = 0; cmd_wr = 1; cmd_op = 2'd1; cmd_queue = 5; cmd_qena = 1; cmd_drop = 0;
        @(negedge clk);
        cmd_op = 2'd2; hash_wr = 1; hash_key = 8'h22;
        @(negedge clk);
        cmd_wr = 0; hash_wr = 0;
        l = 0;
        while (cmd_op_rb != 0 && l < 1000) begin l++; @(negedge clk); end
        repeat (3) @(negedge clk);
        check("R4 second cmd not run", int'(cmd_op_rb), 0);
        check("R4 qry_hit untouched", int'(qry_hit), 0);
        do_cmd(0, 2, 0, 0, 0, 0, 0, 0, l);
        check("R4 hash kept", int'(qry_hit), 1);
        check("R4 stored queue", int'(qry_queue), 5);
    endtask

    task automatic t_overwrite;
        int n;
        do_cfg(2, 0, 0, n);
        for (int k = 0; k < DEPTH - 1; k++) add(6, k, 1, 1, 0);
        add(6, 40, 2, 1, 0);
        add(6, 40, 9, 0, 0);
        check("R6 overwrite no err", int'(cmd_err), 0);
        query(6, 40);
        check("R6 new queue", int'(qry_queue), 9);
        check("R6 new qena", int'(qry_qena), 0);
        add(6, 41, 3, 1, 0);
        check("R6 no slot used", int'(cmd_err), 1);
    endtask

    task automatic t_remove;
        add(9, 8'h33, 4, 1, 0);
        remove(9, 8'h33);
        check("R7 remove ok", int'(cmd_err), 0);
        query(9, 8'h33);
        check("R7 gone", int'(qry_hit), 0);
        remove(9, 8'h33);
        check("R7 absent err", int'(cmd_err), 1);
    endtask

    task automatic t_bucket_cap;
        for (int k = 0; k < DEPTH; k++) add(12, 100 + k, 2, 1, 0);
        check("R8 tenth ok", int'(cmd_err), 0);
        add(12, 200, 2, 1, 0);
        check("R8 eleventh err", int'(cmd_err), 1);
        query(12, 200);
        check("R8 not stored", int'(qry_hit), 0);
        query(12, 109);
        check("R8 tenth kept", int'(qry_hit), 1);
    endtask

    task automatic t_alias;
        int n;
        do_cfg(0, 0, 0, n);
        add(1, 7, 2, 1, 0);
        query(5, 7);
        check("R9 code0 alias", int'(qry_hit), 1);
        do_cfg(2, 0, 0, n);
        add(1, 7, 2, 1, 0);
        query(5, 7);
        check("R9 code2 distinct", int'(qry_hit), 0);
        do_cfg(3, 0, 0, n);
        add(1, 7, 2, 1, 0);
        query(13, 7);
        check("R9 code3 as code0", int'(qry_hit), 1);
    endtask

    task automatic t_invalid_hash;
        int l;
        do_cmd(1, 1, 4, 8'h55, 0, 3, 1, 0, l);
        check("R10 invalid add err", int'(cmd_err), 1);
        query(4, 8'h55);
        check("R10 not stored", int'(qry_hit), 0);
    endtask

    task automatic t_drop;
        int n;
        do_cfg(2, 1, 9, n);
        add(8, 8'h44, 2, 1, 1);
        check("R11 perfect drop ok", int'(cmd_err), 0);
        query(8, 8'h44);
        check("R11 drop queue", int'(qry_queue), 9);
        do_cfg(2, 0, 9, n);
        add(8, 8'h44, 2, 1, 1);
        check("R11 signature drop err", int'(cmd_err), 1);
        query(8, 8'h44);
        check("R11 not stored", int'(qry_hit), 0);
    endtask

    task automatic t_clear;
        int n;
        add(10, 8'h66, 1, 1, 0);
        do_cfg(2, 0, 0, n);
        query(10, 8'h66);
        check("R13 cleared by cfg", int'(qry_hit), 0);
    endtask

    task automatic t_irq;
        int n;
        int cap = NB * DEPTH;
        do_cfg(2, 0, 0, n);
        check("R12 empty no irq", int'(irq_nearly_full), 0);
        for (int i = 0; i < cap - THR; i++) begin
            add(i % NB, 150 + i / NB, 1, 1, 0);
            if (i == cap - THR - 2)
                check("R12 one above threshold", int'(irq_nearly_full), 0);
        end
        check("R12 at threshold", int'(irq_nearly_full), 1);
        remove(0, 150);
        check("R12 drops after remove", int'(irq_nearly_full), 0);
        do_cfg(0, 0, 0, n);
        check("R12 small capacity", int'(irq_nearly_full), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pre_init();
        t_init_timing();
        t_add_query();
        t_busy_ignore();
        t_overwrite();
        t_remove();
        t_bucket_cap();
        t_invalid_hash();
        t_alias();
        t_drop();
        t_clear();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule